// File: doc/BRIEF.md
# CAN Controller Clock-Stop Handshake

This block lets software put a CAN protocol engine into a clock-stopped, power-down state without cutting a frame in half. A stop can be asked for in two ways: through a request bit in the engine's own control register, or through a stop-request level driven by the surrounding wrapper. The engine's request bit reads back as set whenever the wrapper is asking. Once a request is seen, the block waits for the transmitter to go quiet, then for the bus to be idle. It then forces initialization mode, which blocks further traffic, and raises a stop acknowledge one clock later. The wrapper's acknowledge-status bit shows the same value.

While the acknowledge is high, software may gate the module clocks by dropping its clock-enable wish. The block only lets that wish through while acknowledged. To leave, software turns the clocks back on and clears both requests. The block then lowers the acknowledge. Initialization mode stays set until software clears it. If automatic wakeup and the wakeup-request enable are both on, a falling edge on the synchronized receive line during clock stop raises a sticky wakeup request.

Bit timing, message storage and the actual clock gating cells are outside the block. The transmitter's busy flag, the bus-idle flag and the clock enable are plain 1-bit signals.

Top module: `canx_clkstop_ctrl`

## Requirements
- R1: After reset, `init_mode`, `stop_ack`, `wrap_ack_sts`, `wake_req` and `core_req_rd` are 0, and `clk_en_req` is 1.
- R2: `core_req_rd` is 1 in any cycle where `wrap_stop_req` is 1 or the stored engine request bit is 1. The stored bit is written through `core_req_wr_en`/`core_req_wr_val` and takes effect at the next clock edge.
- R3: While `tx_busy` is 1, the stop sequence does not advance past transmit draining, and `bus_idle` is ignored.
- R4: The stop sequence takes one clock to see a request, and one clock to leave draining once `tx_busy` is 0. In the waiting step, `init_mode` rises at the first edge that samples `bus_idle` high. `stop_ack` rises exactly one clock after `init_mode`.
- R5: `wrap_ack_sts` equals `stop_ack` in every cycle.
- R6: A write to `init_mode` (`init_wr_en`) takes effect at the next edge. It is ignored from the edge that forces `init_mode` until `stop_ack` falls.
- R7: `clk_en_req` is 1 whenever `stop_ack` is 0. While `stop_ack` is 1, it follows `sw_clk_en`.
- R8: `stop_ack` falls at the first edge where both requests are clear and `clk_en_req` is 1. It holds while `clk_en_req` is 0, even with both requests clear.
- R9: `init_mode` stays 1 after exit from clock stop until software writes it to 0.
- R10: `wake_req` rises 3 clocks after `rx_in` falls, but only if `stop_ack`, `auto_wake_en` and `wake_req_en` are all 1. It then stays 1 until both requests are clear, and it falls one edge after the combined request is seen clear.
- R11: If the requests are withdrawn before `init_mode` is forced, the block returns to normal running. `init_mode` is left unchanged and `stop_ack` never rises.
- R12: `stop_ack` is never 1 while `init_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req_wr_en | input | 1 | Write strobe for the engine's stop request bit |
| core_req_wr_val | input | 1 | Value written to the engine's stop request bit |
| wrap_stop_req | input | 1 | Wrapper stop-request level |
| init_wr_en | input | 1 | Write strobe for the initialization-mode bit |
| init_wr_val | input | 1 | Value written to the initialization-mode bit |
| tx_busy | input | 1 | Transmit requests still pending |
| bus_idle | input | 1 | Bus idle flag from the bit-level engine |
| sw_clk_en | input | 1 | Software's module clock enable wish |
| rx_in | input | 1 | Asynchronous receive line |
| auto_wake_en | input | 1 | Automatic wakeup enable |
| wake_req_en | input | 1 | Wakeup request enable |
| core_req_rd | output | 1 | Read value of the engine's stop request bit |
| init_mode | output | 1 | Initialization-mode bit |
| stop_ack | output | 1 | Clock-stop acknowledge |
| wrap_ack_sts | output | 1 | Wrapper copy of the acknowledge |
| clk_en_req | output | 1 | Module clock enable request |
| wake_req | output | 1 | Sticky wakeup request |

## Verification
The entry sequence is swept over every transmit-busy length from 0 to 3 clocks and every bus-idle delay from 0 to 3 clocks. Each length and delay is tried with a request from the engine bit and from the wrapper level. The bench checks `init_mode` and `stop_ack` on every cycle against a cycle count it computes. Bus idle is also held high while the transmitter is busy, which shows that it is ignored during draining. That tells an early force apart from a correct one.

Each pass also checks these things:
- An initialization write during the stop is ignored.
- A gated clock holds the acknowledge.
- Turning the clock back on releases it.
- Initialization mode survives the exit.

Further runs withdraw the request in each pre-acknowledge step. Others try every wakeup-enable pair, and a receive falling edge outside clock stop, to separate true wakeups from false ones.

// File: rtl/canx_cs_pkg.sv
package canx_cs_pkg;

    typedef enum logic [2:0] {
        CS_RUN       = 3'd0,
        CS_DRAIN_TX  = 3'd1,
        CS_WAIT_IDLE = 3'd2,
        CS_STOPPED   = 3'd3,
        CS_EXITING   = 3'd4
    } cs_state_e;

    typedef struct packed {
        cs_state_e state;
        logic      init;
        logic      ack;
    } cs_fsm_regs_t;

endpackage

// File: rtl/canx_cs_fsm.sv
module canx_cs_fsm
    import canx_cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic tx_busy,
    input  logic bus_idle,
    input  logic init_wr_en,
    input  logic init_wr_val,
    input  logic sw_clk_en,
    output logic init_o,
    output logic ack_o,
    output logic clk_en_o
);

    cs_fsm_regs_t r_d, r_q;

    assign init_o   = r_q.init;
    assign ack_o    = r_q.ack;
    assign clk_en_o = ~r_q.ack | sw_clk_en;

    always_comb begin
        r_d = r_q;
        // software write, locked while the stop step owns the bit
        if (init_wr_en && (r_q.state != CS_STOPPED)) begin
            r_d.init = init_wr_val;
        end
        unique case (r_q.state)
            CS_RUN: begin
                if (stop_req) r_d.state = CS_DRAIN_TX;
            end
            CS_DRAIN_TX: begin
                if (!stop_req)     r_d.state = CS_RUN;
                else if (!tx_busy) r_d.state = CS_WAIT_IDLE;
            end
            CS_WAIT_IDLE: begin
                if (!stop_req) begin
                    r_d.state = CS_RUN;
                end else if (bus_idle) begin
                    r_d.init  = 1'b1;
                    r_d.state = CS_STOPPED;
                end
            end
            CS_STOPPED: begin
                if (!r_q.ack) begin
                    if (!stop_req) r_d.state = CS_RUN;
                    else           r_d.ack   = 1'b1;
                end else if (!stop_req && clk_en_o) begin
                    r_d.ack   = 1'b0;
                    r_d.state = CS_EXITING;
                end
            end
            CS_EXITING: begin
                r_d.state = CS_RUN;
            end
            default: begin
                r_d.state = CS_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: CS_RUN, init: 1'b0, ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // R12: acknowledge only with initialization mode set
    a_r12_ack_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ack |-> r_q.init);

    // R4: acknowledge rises only after init was already set
    a_r4_ack_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ack) |-> $past(r_q.init));

    // R8: a gated clock holds the acknowledge
    a_r8_hold_while_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ack && !clk_en_o) |=> r_q.ack);

    // R6: init bit cannot move while acknowledged
    a_r6_init_locked: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ack |=> $stable(r_q.init));

    // R3: no force while transmitter busy
    a_r3_no_force_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !r_q.init && (r_q.state != CS_WAIT_IDLE)) |=> !r_q.ack);

endmodule

// File: rtl/canx_rx_wake.sv
module canx_rx_wake #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic stop_ack,
    input  logic stop_req,
    input  logic auto_en,
    input  logic wake_en,
    output logic wake_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   wake;
    } wk_regs_t;

    wk_regs_t w_d, w_q;
    logic     fall;

    assign fall   = w_q.prev & ~w_q.sync[LAST];
    assign wake_o = w_q.wake;

    always_comb begin
        w_d      = w_q;
        w_d.sync = {w_q.sync[LAST-1:0], rx_in};
        w_d.prev = w_q.sync[LAST];
        if (!stop_req) begin
            w_d.wake = 1'b0;
        end else if (stop_ack && auto_en && wake_en && fall) begin
            w_d.wake = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{sync: '1, prev: 1'b1, wake: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    // R10: wakeup only raised during acknowledged stop with both enables
    a_r10_wake_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_q.wake) |-> ($past(stop_ack) && $past(auto_en) && $past(wake_en)));

    // R10: wakeup is sticky while a request remains
    a_r10_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.wake && stop_req) |=> w_q.wake);

endmodule

// File: rtl/canx_clkstop_ctrl.sv
module canx_clkstop_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_req_wr_en,
    input  logic core_req_wr_val,
    input  logic wrap_stop_req,
    input  logic init_wr_en,
    input  logic init_wr_val,
    input  logic tx_busy,
    input  logic bus_idle,
    input  logic sw_clk_en,
    input  logic rx_in,
    input  logic auto_wake_en,
    input  logic wake_req_en,
    output logic core_req_rd,
    output logic init_mode,
    output logic stop_ack,
    output logic wrap_ack_sts,
    output logic clk_en_req,
    output logic wake_req
);

    logic core_req_d, core_req_q;
    logic req_any;

    assign req_any      = core_req_q | wrap_stop_req;
    assign core_req_rd  = req_any;
    assign wrap_ack_sts = stop_ack;

    always_comb begin
        core_req_d = core_req_q;
        if (core_req_wr_en) core_req_d = core_req_wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_req_q <= 1'b0;
        else        core_req_q <= core_req_d;
    end

    canx_cs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (req_any),
        .tx_busy    (tx_busy),
        .bus_idle   (bus_idle),
        .init_wr_en (init_wr_en),
        .init_wr_val(init_wr_val),
        .sw_clk_en  (sw_clk_en),
        .init_o     (init_mode),
        .ack_o      (stop_ack),
        .clk_en_o   (clk_en_req)
    );

    canx_rx_wake #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_in   (rx_in),
        .stop_ack(stop_ack),
        .stop_req(req_any),
        .auto_en (auto_wake_en),
        .wake_en (wake_req_en),
        .wake_o  (wake_req)
    );

    // R5: wrapper status mirrors the acknowledge
    a_r5_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ack_sts == stop_ack);

    // R7: clock enable forced on outside acknowledged stop
    a_r7_clk_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_ack |-> clk_en_req);

    // R2: engine request bit reads set whenever wrapper requests
    a_r2_core_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_stop_req |-> core_req_rd);

endmodule

// File: tb/canx_clkstop_ctrl_tb.sv
module canx_clkstop_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req_wr_en = 0, core_req_wr_val = 0, wrap_stop_req = 0;
    logic init_wr_en = 0, init_wr_val = 0, tx_busy = 0, bus_idle = 0;
    logic sw_clk_en = 1, rx_in = 1, auto_wake_en = 0, wake_req_en = 0;
    logic core_req_rd, init_mode, stop_ack, wrap_ack_sts, clk_en_req, wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    canx_clkstop_ctrl #(.SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_req_wr_en(core_req_wr_en), .core_req_wr_val(core_req_wr_val),
        .wrap_stop_req(wrap_stop_req), .init_wr_en(init_wr_en),
        .init_wr_val(init_wr_val), .tx_busy(tx_busy), .bus_idle(bus_idle),
        .sw_clk_en(sw_clk_en), .rx_in(rx_in), .auto_wake_en(auto_wake_en),
        .wake_req_en(wake_req_en), .core_req_rd(core_req_rd),
        .init_mode(init_mode), .stop_ack(stop_ack), .wrap_ack_sts(wrap_ack_sts),
        .clk_en_req(clk_en_req), .wake_req(wake_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rid, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", rid, act, exp, $time);
        end
    endtask

    task automatic clear_init();
        init_wr_en = 1; init_wr_val = 0;
        tick(1);
        init_wr_en = 0;
        chk("R9 software clear", init_mode, 1'b0);
    endtask

    task automatic enter_stop();
        tx_busy = 0; bus_idle = 1;
        core_req_wr_en = 1; core_req_wr_val = 1;
        tick(1);
        core_req_wr_en = 0;
        tick(4);
        chk("R4 stop entered", stop_ack, 1'b1);
    endtask

    task automatic leave_stop();
        sw_clk_en = 1;
        core_req_wr_en = 1; core_req_wr_val = 0; wrap_stop_req = 0;
        tick(1);
        core_req_wr_en = 0;
        tick(2);
        chk("R8 left stop", stop_ack, 1'b0);
        clear_init();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1 init", init_mode, 1'b0);
        chk("R1 ack", stop_ack, 1'b0);
        chk("R1 ack sts", wrap_ack_sts, 1'b0);
        chk("R1 wake", wake_req, 1'b0);
        chk("R1 core rd", core_req_rd, 1'b0);
        chk("R1 clk en", clk_en_req, 1'b1);

        // R2: wrapper level reads through engine bit; R11 withdraw in draining
        tx_busy = 1;
        wrap_stop_req = 1;
        #1 chk("R2 wrapper tracked", core_req_rd, 1'b1);
        tick(2);
        wrap_stop_req = 0;
        tick(4);
        chk("R11 drain withdraw init", init_mode, 1'b0);
        chk("R11 drain withdraw ack", stop_ack, 1'b0);
        core_req_wr_en = 1; core_req_wr_val = 1;
        tick(1);
        core_req_wr_en = 0;
        chk("R2 core bit stored", core_req_rd, 1'b1);
        core_req_wr_en = 1; core_req_wr_val = 0;
        tick(1);
        core_req_wr_en = 0;
        tick(4);
        chk("R11 core withdraw ack", stop_ack, 1'b0);
        // R11 withdraw while waiting for idle
        tx_busy = 0; bus_idle = 0;
        wrap_stop_req = 1;
        tick(3);
        wrap_stop_req = 0;
        tick(4);
        chk("R11 wait withdraw init", init_mode, 1'b0);
        chk("R11 wait withdraw ack", stop_ack, 1'b0);

        // R3/R4 sweep: source, busy length, idle delay
        for (int src = 0; src < 2; src++) begin
            for (int b = 0; b < 4; b++) begin
                for (int d = 0; d < 4; d++) begin
                    int lat, kd, kp;
                    lat = (src == 0) ? 1 : 0;
                    kd  = (b + 1 > 2) ? b + 1 : 2;
                    kp  = (kd + 1 > b + 2 + d) ? kd + 1 : b + 2 + d;
                    kp  = kp + lat;
                    for (int k = 1; k <= kp + 1; k++) begin
                        int j;
                        j = k - lat;
                        if (src == 0) begin
                            core_req_wr_en = (k == 1); core_req_wr_val = 1;
                        end else begin
                            wrap_stop_req = 1;
                        end
                        tx_busy  = (j <= b);
                        bus_idle = (j <= b) ? 1'b1 : (j >= b + 2 + d);
                        tick(1);
                        core_req_wr_en = 0;
                        chk("R3/R4 init timing", init_mode, k >= kp);
                        chk("R4 ack timing", stop_ack, k >= kp + 1);
                    end
                    chk("R5 status mirror", wrap_ack_sts, 1'b1);
                    tx_busy = 0; bus_idle = 0;
                    // R6 write ignored while acknowledged
                    init_wr_en = 1; init_wr_val = 0;
                    tick(1);
                    init_wr_en = 0;
                    chk("R6 init write ignored", init_mode, 1'b1);
                    chk("R2 read during stop", core_req_rd, 1'b1);
                    // R7/R8 gate clock, clear requests
                    sw_clk_en = 0;
                    #1 chk("R7 clock gated", clk_en_req, 1'b0);
                    core_req_wr_en = 1; core_req_wr_val = 0; wrap_stop_req = 0;
                    tick(1);
                    core_req_wr_en = 0;
                    tick(2);
                    chk("R8 ack held while gated", stop_ack, 1'b1);
                    sw_clk_en = 1;
                    #1 chk("R7 clock restored", clk_en_req, 1'b1);
                    tick(1);
                    chk("R8 ack cleared", stop_ack, 1'b0);
                    chk("R5 status cleared", wrap_ack_sts, 1'b0);
                    tick(2);
                    chk("R9 init kept", init_mode, 1'b1);
                    clear_init();
                end
            end
        end

        // R10 wakeup with both enables
        auto_wake_en = 1; wake_req_en = 1;
        enter_stop();
        rx_in = 0;
        tick(2);
        chk("R10 wake not yet", wake_req, 1'b0);
        tick(1);
        chk("R10 wake raised", wake_req, 1'b1);
        rx_in = 1;
        tick(4);
        chk("R10 wake sticky", wake_req, 1'b1);
        core_req_wr_en = 1; core_req_wr_val = 0;
        tick(1);
        core_req_wr_en = 0;
        tick(1);
        chk("R10 wake cleared", wake_req, 1'b0);
        tick(2);
        clear_init();

        // R10 enable combinations without both set
        for (int e = 0; e < 3; e++) begin
            auto_wake_en = e[0]; wake_req_en = e[1];
            enter_stop();
            rx_in = 0;
            tick(2);
            rx_in = 1;
            tick(4);
            chk("R10 no wake when disabled", wake_req, 1'b0);
            leave_stop();
        end

        // R10 activity outside clock stop
        auto_wake_en = 1; wake_req_en = 1;
        rx_in = 0;
        tick(5);
        chk("R10 no wake while running", wake_req, 1'b0);
        rx_in = 1;
        tick(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule